// File: doc/BRIEF.md
# Slotted REQ/ACK Data-In Sequencer

This block is the target side of a byte-wide asynchronous SCSI data-in transfer, with data flowing from target to initiator. A free-running slot timer splits time into fixed-length slots of `SLOT_CLKS` clocks. The slots alternate between buffer slots and bus slots. In a buffer slot the sequencer reads the next byte from a local buffer over a one-cycle-latency read port and latches it onto the active-low data lines. At the start of the next bus slot it asserts the active-low REQ. ACK passes through a two-flop synchronizer and is acted on only while a bus slot is running.

When ACK is seen in a bus slot, REQ is released and the next byte is fetched in the buffer slot that follows. That fetch overlaps the initiator's own storage cycle. A prompt ACK gives one byte every two slots. An ACK that misses its bus slot waits for the next one, so the byte takes four slots. A byte down-counter, loaded at `start`, ends the transfer and raises `done`.

Top module: `slotseq_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, the outputs are idle until `start`: `req_n`=1, `db_n`=all ones, `buf_rd`=0, `done`=0.
- R2: Slots are `SLOT_CLKS` clocks long and alternate, starting with a buffer slot after reset. `buf_rd` pulses only on the first clock of a buffer slot. `buf_rdata` is taken on the clock after `buf_rd`.
- R3: `req_n` falls only at the first edge inside a bus slot. At that point `db_n` already carries the bitwise inverse of the byte read from the current address.
- R4: `db_n` does not change while `req_n` is low.
- R5: ACK (`ack_n`=0) is synchronized through two flops and acted on only in a bus slot. REQ is released on the clock after a synchronized ACK is seen in a bus slot, and an ACK that arrives during a buffer slot leaves REQ asserted.
- R6: When ACK is prompt, successive falling edges of `req_n` are 2 slots apart. When ACK misses one bus slot, they are 4 slots apart.
- R7: REQ is not re-asserted while the synchronized ACK is still asserted (four-phase interlock).
- R8: Bytes are read from addresses 0, 1, 2, … in order. After `xfer_len` acknowledged bytes `done` goes to 1 and `req_n` stays 1. A `start` with `xfer_len`=0 sets `done` on the next clock without any REQ.
- R9: `start` is accepted when idle or done. It clears `done` on the next clock and restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a transfer |
| xfer_len | input | CNT_W | Number of bytes to send |
| buf_rdata | input | DATA_W | Buffer read data, valid one clock after `buf_rd` |
| ack_n | input | 1 | Initiator acknowledge, active low, asynchronous |
| req_n | output | 1 | Target request, active low |
| db_n | output | DATA_W | Data lines, active low |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rd | output | 1 | Buffer read strobe |
| done | output | 1 | Transfer complete |

## Verification
On every cycle, the in-line properties check the following:
- REQ rises only at a bus-slot boundary and only with ACK released.
- REQ falls only after a synchronized ACK is seen in a bus slot.
- The data stays frozen while REQ is low.
- Buffer reads land in buffer slots.
- `done` keeps REQ quiet.

Some behaviour shows only in the bench's scenarios, each driven by an initiator model with a chosen ACK delay and hold: byte order against the expected buffer contents, the exact 2-slot versus 4-slot byte spacing, the byte count that ends a transfer, and the restart and zero-length cases.

// File: rtl/slotseq_pkg.sv
// Shared types for the slotted data-in sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package slotseq_pkg;

    // Control sequencer states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_BUF = 3'd1,
        ST_CAPTURE  = 3'd2,
        ST_WAIT_BUS = 3'd3,
        ST_PRESENT  = 3'd4,
        ST_DONE     = 3'd5
    } seq_state_t;

endpackage

// File: rtl/slotseq_timer.sv
// Free-running slot timer. Counts SLOT_CLKS clocks per slot and toggles a
// flag at each slot end, so slots alternate buffer / bus, buffer first.
// Assumes SLOT_CLKS >= 3 so a fetch fits inside one buffer slot.
module slotseq_timer #(
    parameter int SLOT_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_first,
    output logic in_bus_slot
);
    localparam int CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CLKS - 1);

    logic [CW-1:0] cnt_q;
    logic          bus_q;
    logic          slot_last;

    assign slot_last   = (cnt_q == LAST);
    assign slot_first  = (cnt_q == '0);
    assign in_bus_slot = bus_q;

    // Clock counter inside the current slot
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (slot_last) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Slot kind flag, toggled at every slot end
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_q <= 1'b0;
        else if (slot_last) bus_q <= ~bus_q;
    end

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> slot_first);

    // R2
    slot_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> (in_bus_slot != $past(in_bus_slot)));

endmodule

// File: rtl/slotseq_ack_sync.sv
// Two-flop synchronizer for the asynchronous active-low acknowledge.
// Output is active high: 1 means the initiator acknowledges.
module slotseq_ack_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic ack_seen
);
    logic s1_q, s2_q;

    // Two-stage capture of the inverted acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= ~ack_n;
            s2_q <= s1_q;
        end
    end

    assign ack_seen = s2_q;

endmodule

// File: rtl/slotseq_ctrl.sv
// Control sequencer. Fetches a byte on the first clock of a buffer slot,
// latches the read data one clock later, raises REQ at the next bus-slot
// start once ACK is released, and drops REQ when ACK is seen in a bus slot.
// Assumes a buffer with one clock of read latency.
module slotseq_ctrl
    import slotseq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic [DATA_W-1:0] buf_rdata,
    input  logic              ack_seen,
    input  logic              slot_first,
    input  logic              in_bus_slot,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_o,
    output logic              done_o
);
    seq_state_t        state_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              req_q;
    logic              can_start, fetch_now, raise_now, take_ack, last_byte;

    assign can_start = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign fetch_now = (state_q == ST_WAIT_BUF) && slot_first && !in_bus_slot;
    assign raise_now = (state_q == ST_WAIT_BUS) && slot_first && in_bus_slot && !ack_seen;
    assign take_ack  = (state_q == ST_PRESENT) && in_bus_slot && ack_seen;
    assign last_byte = (left_q == CNT_W'(1));

    // Next-state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: if (can_start)
                    state_q <= (xfer_len == '0) ? ST_DONE : ST_WAIT_BUF;
                ST_WAIT_BUF: if (fetch_now) state_q <= ST_CAPTURE;
                ST_CAPTURE:  state_q <= ST_WAIT_BUS;
                ST_WAIT_BUS: if (raise_now) state_q <= ST_PRESENT;
                ST_PRESENT:  if (take_ack)
                    state_q <= last_byte ? ST_DONE : ST_WAIT_BUF;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    // Byte count and buffer address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            addr_q <= '0;
        end else if (can_start) begin
            left_q <= xfer_len;
            addr_q <= '0;
        end else if (take_ack) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + 1'b1;
        end
    end

    // Data latch, loaded one clock after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (state_q == ST_CAPTURE)  data_q <= buf_rdata;
    end

    // Request flag
    always_ff @(posedge clk) begin
        if (!rst_n)         req_q <= 1'b0;
        else if (raise_now) req_q <= 1'b1;
        else if (take_ack)  req_q <= 1'b0;
    end

    assign req_o  = req_q;
    assign data_o = data_q;
    assign addr_o = addr_q;
    assign rd_o   = fetch_now;
    assign done_o = (state_q == ST_DONE);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && $past(req_q)) |-> $stable(data_q));

    // R3
    req_rise_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(in_bus_slot && slot_first));

    // R5
    req_fall_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(ack_seen && in_bus_slot));

    // R7
    req_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(!ack_seen));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_q);

endmodule

// File: rtl/slotseq_target.sv
// Top of the slotted target data-in sequencer. Joins the slot timer, the
// acknowledge synchronizer and the control sequencer, and converts REQ and
// data to active-low bus levels.
// Assumes the buffer returns data one clock after buf_rd.
module slotseq_target #(
    parameter int SLOT_CLKS = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic [DATA_W-1:0] buf_rdata,
    input  logic              ack_n,
    output logic              req_n,
    output logic [DATA_W-1:0] db_n,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd,
    output logic              done
);
    logic              slot_first, in_bus_slot, ack_seen, req_hi;
    logic [DATA_W-1:0] data_hi;

    slotseq_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_first  (slot_first),
        .in_bus_slot (in_bus_slot)
    );

    slotseq_ack_sync u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (ack_n),
        .ack_seen (ack_seen)
    );

    slotseq_ctrl #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .xfer_len    (xfer_len),
        .buf_rdata   (buf_rdata),
        .ack_seen    (ack_seen),
        .slot_first  (slot_first),
        .in_bus_slot (in_bus_slot),
        .req_o       (req_hi),
        .data_o      (data_hi),
        .addr_o      (buf_addr),
        .rd_o        (buf_rd),
        .done_o      (done)
    );

    // Active-low bus levels
    assign req_n = ~req_hi;
    assign db_n  = ~data_hi;

    // R2
    read_in_buf_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> !in_bus_slot);

endmodule

// File: tb/slotseq_target_bench.sv
`timescale 1ns/1ps
module slotseq_target_bench;
    localparam int SLOT = 8;
    localparam int CW = 16, AW = 12, DW = 8;

    // {length, ack delay (negedges), ack hold after REQ release, expected spacing (0 = skip)}
    localparam int NVEC = 5;
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{6,  0,  0, 2*SLOT},
        '{5,  3,  0, 2*SLOT},
        '{5,  6,  0, 4*SLOT},
        '{4, 12,  0, 4*SLOT},
        '{4,  0, 40, 0}
    };

    logic clk = 0, rst_n = 0, start = 0, ack_n = 1;
    logic [CW-1:0] xfer_len = '0;
    logic [DW-1:0] buf_rdata = '0;
    logic req_n, buf_rd, done;
    logic [DW-1:0] db_n;
    logic [AW-1:0] buf_addr;

    int total = 0, bad = 0, cyc = 0;
    int cur_delay = 0, cur_hold = 0, cur_period = 0, nbytes = 0, t_prev = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slotseq_target #(.SLOT_CLKS(SLOT), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) u_slotseq_target (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .buf_rdata(buf_rdata), .ack_n(ack_n), .req_n(req_n), .db_n(db_n),
        .buf_addr(buf_addr), .buf_rd(buf_rd), .done(done));

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    // Buffer model with one clock of read latency
    always @(posedge clk) if (buf_rd) buf_rdata <= pattern(int'(buf_addr));

    task automatic check(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Initiator model: records each byte, acknowledges after a delay, holds ACK
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !req_n && ack_n) begin
                // R3 R8: byte order and active-low data
                check("R8 byte", (~db_n) == pattern(nbytes), int'(~db_n), int'(pattern(nbytes)));
                // R6: spacing between successive REQ assertions
                if (nbytes > 0 && cur_period != 0)
                    check("R6 spacing", (cyc - t_prev) == cur_period, cyc - t_prev, cur_period);
                t_prev = cyc;
                nbytes++;
                repeat (cur_delay) begin
                    @(negedge clk);
                end
                // R5: REQ must still be held when ACK arrives
                check("R5 req held", req_n == 1'b0, int'(req_n), 0);
                ack_n = 0;
                while (!req_n) @(negedge clk);
                repeat (cur_hold) begin
                    @(negedge clk);
                    // R7: no new REQ while ACK is held
                    check("R7 interlock", req_n == 1'b1, int'(req_n), 1);
                end
                ack_n = 1;
            end
        end
    end

    task automatic run(input int len, input int dly, input int hold, input int period);
        int waited = 0;
        cur_delay = dly; cur_hold = hold; cur_period = period; nbytes = 0;
        @(negedge clk);
        xfer_len = CW'(len); start = 1;
        @(negedge clk);
        start = 0;
        // R9: start clears done
        check("R9 done clear", done == 1'b0, int'(done), 0);
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check("R8 done", done == 1'b1, int'(done), 1);
        while (!ack_n) @(negedge clk);
        repeat (3 * SLOT) @(negedge clk);
        check("R8 count", nbytes == len, nbytes, len);
        check("R8 req idle", req_n == 1'b1, int'(req_n), 1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 req_n", req_n == 1'b1, int'(req_n), 1);
        check("R1 db_n", db_n == '1, int'(db_n), 255);
        check("R1 buf_rd", buf_rd == 1'b0, int'(buf_rd), 0);
        check("R1 done", done == 1'b0, int'(done), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check("R1 idle req", req_n == 1'b1, int'(req_n), 1);

        for (int i = 0; i < NVEC; i++)
            run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

        // R8: zero-length transfer finishes with no REQ
        nbytes = 0;
        @(negedge clk);
        xfer_len = '0; start = 1;
        @(negedge clk);
        start = 0;
        check("R8 zero done", done == 1'b1, int'(done), 1);
        repeat (4 * SLOT) @(negedge clk);
        check("R8 zero no req", nbytes == 0, nbytes, 0);

        // R9: restart after a zero-length transfer still begins at address 0
        run(3, 0, 0, 2*SLOT);

        // R1: reset in mid-transfer returns to idle
        cur_delay = 200; nbytes = 0;
        @(negedge clk);
        xfer_len = CW'(4); start = 1;
        @(negedge clk);
        start = 0;
        repeat (6 * SLOT) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check("R1 reset req", req_n == 1'b1, int'(req_n), 1);
        check("R1 reset done", done == 1'b0, int'(done), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule